// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped by looking only at its 48-bit destination address. Each address is sorted into one of three kinds: broadcast, multicast or unicast. It is then tested against six accept paths. Three of them accept a whole kind of address. Two of them accept an address whose CRC-derived bucket is marked in a 64-bit hash table. The last accepts an exact match with the station address. A frame is accepted when at least one enabled path matches.

The same matches can also wake a sleeping system. A sticky status register records which enabled paths matched while the filter wake enable was on. A separate status bit records a magic-packet match reported by an external detector while the magic wake enable was on. The wake interrupt stays high while any status bit is set. Software clears status bits by writing ones to a clear port.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, accept_valid, accept, wake_irq, ctrl_rdata and wake_status are all 0.
- R2: A write on ctrl_wr stores ctrl_wdata into the control register. Only bits 0-5, 12 and 13 are kept. All other bits of ctrl_rdata read as 0.
- R3: The address kinds are defined as follows, with dst_addr[47:40] as the first octet. Broadcast means all 48 bits are 1. Multicast means bit 40 is 1 and the address is not broadcast. Every other address is unicast. Control bit 0 accepts every unicast address, bit 1 every broadcast address and bit 2 every multicast address.
- R4: With control bit 5 set, an address equal to station_addr is accepted, whatever its kind.
- R5: The hash index is bits [28:23] of a CRC-32 register. The register uses the reflected polynomial 0xEDB88320 and starts at all ones. It processes the first octet first, least significant bit first, and has no final inversion. When hash_table[index] is 1, a unicast address is accepted if control bit 3 is set, and a multicast address is accepted if control bit 4 is set. Broadcast addresses never use the hash paths.
- R6: accept_valid is high for exactly the one cycle after the edge that sampled dst_valid. In that cycle, accept is 1 exactly when some enabled path matches.
- R7: On a sampled frame with control bit 13 set, wake_status bit n (0-5) is set for each path n that is enabled and matches. With bit 13 clear, the frame sets no status bit.
- R8: magic_match sampled while control bit 12 is set sets wake_status bit 8. While bit 12 is clear, magic_match has no effect.
- R9: Status bits are sticky. A write on clr_wr clears the bits where clr_wdata is 1. When a bit is set and cleared in the same cycle, the set wins. Bits 6, 7 and 9-31 read 0.
- R10: wake_irq is 1 exactly when any wake_status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_valid | input | 1 | Destination address strobe, one per frame |
| dst_addr | input | 48 | Destination address, first octet in [47:40] |
| station_addr | input | 48 | Station address for exact match |
| hash_table | input | 64 | Hash bucket enables |
| magic_match | input | 1 | Magic-packet detector hit |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 14 | Control register write data |
| ctrl_rdata | output | 32 | Control register readback |
| clr_wr | input | 1 | Status clear strobe |
| clr_wdata | input | 9 | Status bits to clear |
| wake_status | output | 32 | Sticky wake-cause register |
| wake_irq | output | 1 | Wake interrupt |
| accept_valid | output | 1 | Decision strobe |
| accept | output | 1 | Accept (1) or drop (0) |

## Verification
The matching logic is combinational and feeds a single register stage. A wrong classification, a wrong hash bucket or a wrong enable bit therefore shows up in accept in the very cycle accept_valid rises. A stuck or wrongly cleared status bit shows up in wake_status and wake_irq on the next sampled cycle. It then stays visible until the next clear, so the bench compares status after every frame and every clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W    = 48;
  localparam int OCTETS    = ADDR_W / 8;
  localparam int CRC_W     = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam int NPATH     = 6;
  localparam int P_UCAST   = 0;
  localparam int P_BCAST   = 1;
  localparam int P_MCAST   = 2;
  localparam int P_UHASH   = 3;
  localparam int P_MHASH   = 4;
  localparam int P_PERFECT = 5;
  localparam int CTRL_W    = 14;
  localparam int WAKE_MAGIC_BIT = 12;
  localparam int WAKE_FILT_BIT  = 13;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 14'h303F;
  localparam int STAT_W    = 9;
  localparam int MAGIC_STAT_BIT = 8;
  typedef logic [NPATH-1:0] path_vec_t;
endpackage

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6,
  parameter int HASH_LSB  = 23
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [HASH_BITS-1:0] idx
);
  always_comb begin
    logic [CRC_W-1:0] crc;
    logic [7:0]       oct;
    logic             fb;
    crc = '1;
    for (int o = 0; o < OCTETS; o++) begin
      oct = addr[ADDR_W-1-8*o -: 8];
      for (int b = 0; b < 8; b++) begin
        fb  = crc[0] ^ oct[b];
        crc = (crc >> 1) ^ (fb ? CRC_POLY : '0);
      end
    end
    idx = crc[HASH_LSB +: HASH_BITS];
  end
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6,
  localparam int TBL_N    = 1 << HASH_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    station,
  input  logic [TBL_N-1:0]     table_bits,
  input  logic [HASH_BITS-1:0] hash_idx,
  output path_vec_t            hit
);
  logic is_bcast, is_mcast, is_ucast, bucket_on;

  always_comb begin
    is_bcast  = &addr;
    is_mcast  = addr[ADDR_W-8] & ~is_bcast;
    is_ucast  = ~addr[ADDR_W-8];
    bucket_on = table_bits[hash_idx];
    hit            = '0;
    hit[P_UCAST]   = is_ucast;
    hit[P_BCAST]   = is_bcast;
    hit[P_MCAST]   = is_mcast;
    hit[P_UHASH]   = is_ucast & bucket_on;
    hit[P_MHASH]   = is_mcast & bucket_on;
    hit[P_PERFECT] = (addr == station);
  end

  // R3: exactly one address kind
  always_comb begin
    a_one_kind_r3: assert ($onehot({is_bcast, is_mcast, is_ucast}));
  end
endmodule

// File: rtl/rxf_wake.sv
module rxf_wake
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  path_vec_t         grant,
  input  logic              filt_wake_en,
  input  logic              magic_stb,
  input  logic              magic_wake_en,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] status_q, status_d, set_vec, clr_vec;
  logic              upd;

  always_comb begin
    set_vec = '0;
    if (frame_stb && filt_wake_en) set_vec[NPATH-1:0] = grant;
    if (magic_stb && magic_wake_en) set_vec[MAGIC_STAT_BIT] = 1'b1;
    clr_vec  = clr_wr ? clr_mask : '0;
    upd      = (|set_vec) | clr_wr;
    status_d = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (upd) status_q <= status_d;
  end

  assign status = status_q;
  assign irq    = |status_q;

  // R9: without a clear, no set bit falls
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R8: magic without enable leaves its bit alone
  p_magic_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (magic_stb && !magic_wake_en && !status_q[MAGIC_STAT_BIT] && !clr_wr)
    |=> !status_q[MAGIC_STAT_BIT]);
  // R7: filter wake disabled -> frame sets nothing new in path bits
  p_filt_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_wake_en) |=> ((status_q[NPATH-1:0] & ~$past(status_q[NPATH-1:0])) == '0));
  // R10: interrupt rises only after a set source
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|set_vec));
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6,
  parameter int HASH_LSB  = 23,
  localparam int TBL_N    = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [TBL_N-1:0]  hash_table,
  input  logic              magic_match,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [31:0]       ctrl_rdata,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_wdata,
  output logic [31:0]       wake_status,
  output logic              wake_irq,
  output logic              accept_valid,
  output logic              accept
);
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [HASH_BITS-1:0] hidx;
  path_vec_t            hit, grant;
  logic                 acc_q, acc_d, accv_q;
  logic [STAT_W-1:0]    status;

  rxf_hash #(.HASH_BITS(HASH_BITS), .HASH_LSB(HASH_LSB)) i_hash (
    .addr(dst_addr), .idx(hidx));

  rxf_classify #(.HASH_BITS(HASH_BITS)) i_class (
    .addr(dst_addr), .station(station_addr), .table_bits(hash_table),
    .hash_idx(hidx), .hit(hit));

  always_comb begin
    ctrl_d = ctrl_wdata & CTRL_MASK;
    grant  = hit & ctrl_q[NPATH-1:0];
    acc_d  = |grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      accv_q <= 1'b0;
    end else begin
      accv_q <= dst_valid;
      if (dst_valid) acc_q <= acc_d;
    end
  end

  rxf_wake i_wake (
    .clk(clk), .rst_n(rst_n), .frame_stb(dst_valid), .grant(grant),
    .filt_wake_en(ctrl_q[WAKE_FILT_BIT]), .magic_stb(magic_match),
    .magic_wake_en(ctrl_q[WAKE_MAGIC_BIT]), .clr_wr(clr_wr),
    .clr_mask(clr_wdata), .status(status), .irq(wake_irq));

  assign ctrl_rdata   = {{(32-CTRL_W){1'b0}}, ctrl_q};
  assign wake_status  = {{(32-STAT_W){1'b0}}, status};
  assign accept_valid = accv_q;
  assign accept       = acc_q & accv_q;

  // R6: decision strobe follows the address strobe by one cycle
  p_decide_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_valid |-> $past(dst_valid));
  // R6: nothing accepted with every path disabled
  p_accept_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && ctrl_q[NPATH-1:0] == '0) |=> !accept);
  // R2: reserved control bits stay clear
  p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_rdata[11:6] == '0 && ctrl_rdata[31:14] == '0));
endmodule

// File: tb/test_rxf_addr_filter.sv
module test_rxf_addr_filter;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic dst_valid = 0, magic_match = 0, ctrl_wr = 0, clr_wr = 0;
  logic [47:0] dst_addr = '0, station_addr = 48'h02AB_CD12_3456;
  logic [63:0] hash_table = '0;
  logic [13:0] ctrl_wdata = '0;
  logic [8:0]  clr_wdata = '0;
  logic [31:0] ctrl_rdata, wake_status;
  logic wake_irq, accept_valid, accept;
  int errors = 0, checks = 0;
  logic [13:0] m_ctrl = '0;
  logic [31:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxf_addr_filter i_rxf_addr_filter (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] m_hash(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      int byte_n = i / 8;
      int bit_n  = i % 8;
      logic d = a[47 - 8*byte_n - 7 + bit_n];
      logic top = r[0] ^ d;
      r = {1'b0, r[31:1]};
      if (top) r = r ^ 32'hEDB88320;
    end
    return r[28:23];
  endfunction

  function automatic logic [5:0] m_paths(input logic [47:0] a);
    logic [5:0] p = '0;
    logic b = (a == 48'hFFFF_FFFF_FFFF);
    logic m = a[40] && !b;
    logic u = !a[40];
    logic h = hash_table[m_hash(a)];
    p[0] = u; p[1] = b; p[2] = m; p[3] = u && h; p[4] = m && h;
    p[5] = (a == station_addr);
    return p & m_ctrl[5:0];
  endfunction

  task automatic wr_ctrl(input logic [13:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
    m_ctrl = v & 14'h303F;
    chk(ctrl_rdata == {18'b0, m_ctrl}, "R2 ctrl readback", ctrl_rdata, m_ctrl);
  endtask

  task automatic wr_clr(input logic [8:0] v);
    @(negedge clk); clr_wr = 1; clr_wdata = v;
    @(negedge clk); clr_wr = 0;
    m_stat = m_stat & ~{23'b0, v};
    chk(wake_status == m_stat, "R9 clear", wake_status, m_stat);
    chk(wake_irq == (m_stat != 0), "R10 irq", wake_irq, m_stat != 0);
  endtask

  task automatic frame(input logic [47:0] a, input logic mg, input string req);
    logic [5:0] p;
    @(negedge clk);
    p = m_paths(a);
    dst_valid = 1; dst_addr = a; magic_match = mg;
    @(negedge clk);
    dst_valid = 0; magic_match = 0;
    if (m_ctrl[13]) m_stat[5:0] = m_stat[5:0] | p;
    if (mg && m_ctrl[12]) m_stat[8] = 1'b1;
    chk(accept_valid === 1'b1, {req, " R6 strobe"}, accept_valid, 1);
    chk(accept === (p != 0), {req, " accept"}, accept, p != 0);
    chk(wake_status == m_stat, {req, " R7 status"}, wake_status, m_stat);
    chk(wake_irq == (m_stat != 0), {req, " R10 irq"}, wake_irq, m_stat != 0);
    @(negedge clk);
    chk(accept_valid === 1'b0, "R6 one-cycle strobe", accept_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD*2000000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3); @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(accept_valid == 0 && accept == 0, "R1 decision", {accept_valid, accept}, 0);
    chk(ctrl_rdata == 0 && wake_status == 0 && wake_irq == 0, "R1 regs",
        {ctrl_rdata, wake_status}, 0);
    // R2 reserved bits
    wr_ctrl(14'h3FFF);
    wr_ctrl(14'h0FC0);
    // R6 nothing enabled drops everything
    frame(48'hFFFF_FFFF_FFFF, 0, "R6 all off");
    // R3 kinds, wake on
    wr_ctrl(14'h2002);
    frame(48'hFFFF_FFFF_FFFF, 0, "R3 bcast");
    frame(48'h0100_5E00_0001, 0, "R3 mcast not bcast");
    wr_ctrl(14'h2001);
    frame(48'h0011_2233_4455, 0, "R3 ucast");
    wr_ctrl(14'h2004);
    frame(48'h0100_5E00_0001, 0, "R3 mcast");
    wr_clr(9'h1FF);
    // R4 perfect
    wr_ctrl(14'h2020);
    frame(station_addr, 0, "R4 perfect");
    frame(station_addr ^ 48'h1, 0, "R4 near miss");
    // R5 hash: set only the bucket of one address
    hash_table = 64'h1 << m_hash(48'h0A0B_0C0D_0E0F);
    wr_ctrl(14'h2008);
    frame(48'h0A0B_0C0D_0E0F, 0, "R5 uhash hit");
    wr_ctrl(14'h2010);
    frame(48'h0B0B_0C0D_0E0F, 0, "R5 mhash");
    hash_table = '1;
    frame(48'hFFFF_FFFF_FFFF, 0, "R5 bcast bypasses hash");
    // R7 filter wake off sets nothing
    wr_clr(9'h1FF);
    wr_ctrl(14'h003F);
    frame(station_addr, 0, "R7 wake off");
    // R8 magic gating
    frame(48'h0011_2233_4455, 1, "R8 magic disabled");
    wr_ctrl(14'h1000);
    frame(48'h0011_2233_4455, 1, "R8 magic enabled");
    // R9 set wins over same-cycle clear
    @(negedge clk); magic_match = 1; clr_wr = 1; clr_wdata = 9'h100;
    @(negedge clk); magic_match = 0; clr_wr = 0;
    chk(wake_status[8] == 1'b1, "R9 set wins", wake_status, 32'h100);
    wr_clr(9'h0FF);
    chk(wake_status == 32'h100, "R9 partial clear", wake_status, 32'h100);
    wr_clr(9'h100);
    // random
    for (int n = 0; n < 400; n++) begin
      logic [47:0] a;
      int k = $urandom_range(0, 7);
      if (n % 25 == 0) begin
        hash_table = {$urandom, $urandom};
        wr_ctrl(14'($urandom));
      end
      if (n % 40 == 39) wr_clr(9'($urandom));
      a = {$urandom, $urandom}; 
      if (k == 0) a = '1;
      else if (k == 1) a = station_addr;
      frame(a, ($urandom_range(0, 9) == 0), "R6 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule